// File: doc/BRIEF.md
# Posted Write Buffer with Load Overlap Detection

This block sits between a data cache and the memory system and holds writes that the cache has handed off. Two kinds of traffic fill it: stores that missed the cache, which carry a partial byte mask, and dirty 16-byte subblocks evicted from the cache, which carry a full mask. Every slot keeps the block address, the 16 data bytes and one valid bit per byte. Slots are sent to memory one at a time, oldest first, over a request/acknowledge port.

Loads that miss the cache do not have to wait for the buffer to empty. They may go to memory ahead of pending writes. Every slot compares its stored block address with the address of the probing load. If any occupied slot matches, the load is stalled until that slot has been written, so a load never reads memory contents that a buffered write is about to replace. A full buffer raises a back-pressure signal, and the cache must hold its next write until a slot frees.

Top module: `write_buffer`

## Requirements
- R1: After a synchronous active-low reset the buffer is empty: `mem_req`, `wb_full` and `ld_stall` are all 0, and writes accepted before the reset are never delivered.
- R2: A write presented with `wr_valid` while `wb_full` is 0 is captured on that clock edge. Its delivery repeats the block address unchanged. Byte i of the block is `wr_data[8i+7:8i]`, and mask bit i marks that byte as valid.
- R3: Captured writes are delivered in acceptance order. While `mem_req` is 1 and `mem_ack` is 0, the address, data and mask stay stable. Each cycle with both `mem_req` and `mem_ack` high retires exactly one slot.
- R4: `wb_full` is 1 exactly when 8 slots are occupied. A write presented while full is dropped: it is never delivered and never stalls a load.
- R5: `ld_stall` is 1 when `ld_valid` is 1 and `ld_blk_addr` (byte address bits 31:4) equals the block address of any occupied slot.
- R6: A load whose block address matches no occupied slot is not stalled, even while other writes are pending.
- R7: The stall stays high during the cycle in which the matching slot is acknowledged. It drops in the following cycle, once no other matching slot remains.
- R8: A full-mask eviction and a later partial store to the same block occupy separate slots. After both drain, memory holds the later bytes where its mask is set and the earlier bytes elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Write (store miss or eviction) presented |
| wr_blk_addr | input | 28 | Block address of the write (byte address bits 31:4) |
| wr_data | input | 128 | 16 data bytes, byte i in bits 8i+7:8i |
| wr_mask | input | 16 | Byte valid bits |
| wb_full | output | 1 | All slots occupied; hold writes |
| ld_valid | input | 1 | Load miss probing the buffer |
| ld_blk_addr | input | 28 | Block address of the load |
| ld_stall | output | 1 | Load overlaps a buffered write |
| mem_req | output | 1 | Oldest slot is offered to memory |
| mem_blk_addr | output | 28 | Block address of the offered slot |
| mem_data | output | 128 | Data of the offered slot |
| mem_mask | output | 16 | Byte valid bits of the offered slot |
| mem_ack | input | 1 | Memory accepted the offered slot |

## Verification
The bench builds the block with its default depth of 8 slots. With this depth, holding `mem_ack` low fills every slot within a few dozen cycles, so the back-pressure and the dropped ninth write come within reach. Probes against a half-filled buffer cover matching and non-matching loads, including block addresses that differ only in the lowest tag bit. The drain phase is checked against a byte-level reference memory. That check shows whether two slots holding the same block are merged in acceptance order.

// File: rtl/wb_pkg.sv
// Package wb_pkg
// Shared sizes and the slot record type of the write buffer.
// Assumes 32-bit physical byte addresses and 16-byte blocks.
package wb_pkg;
    localparam int ADDR_W    = 32;
    localparam int BLK_BYTES = 16;
    localparam int DATA_W    = BLK_BYTES * 8;
    localparam int OFS_W     = $clog2(BLK_BYTES);
    localparam int TAG_W     = ADDR_W - OFS_W;

    typedef struct packed {
        logic [TAG_W-1:0]     tag;
        logic [DATA_W-1:0]    data;
        logic [BLK_BYTES-1:0] mask;
    } wb_blk_t;
endpackage

// File: rtl/wb_ptr_ctrl.sv
// Module wb_ptr_ctrl
// Circular write/read indices and occupancy count for the slot array.
// Accepts a push only while not full; a pop is only legal while not empty,
// which the caller guarantees by gating pop with the request it derives
// from 'empty'.
module wb_ptr_ctrl #(
    parameter int DEPTH = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_req,
    input  logic             pop,
    output logic             push_ok,
    output logic [IDX_W-1:0] wr_idx,
    output logic [IDX_W-1:0] rd_idx,
    output logic             empty,
    output logic             full
);
    logic [CNT_W-1:0] count;

    // Occupancy flags derived from the count.
    always_comb begin
        empty   = (count == '0);
        full    = (count == CNT_W'(DEPTH));
        push_ok = push_req && !full;
    end

    // Advance indices with wrap and track occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_idx <= '0;
            rd_idx <= '0;
            count  <= '0;
        end else begin
            if (push_ok)
                wr_idx <= (wr_idx == IDX_W'(DEPTH - 1)) ? '0 : wr_idx + 1'b1;
            if (pop)
                rd_idx <= (rd_idx == IDX_W'(DEPTH - 1)) ? '0 : rd_idx + 1'b1;
            case ({push_ok, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R4
    full_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full && !pop |=> full);

    // R2
    push_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_ok |=> !empty);

    // R3
    pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/wb_slot.sv
// Module wb_slot
// One buffer slot: block record, occupied flag and a block-address
// comparator against the probing load. Assumes load and clear are never
// asserted together.
module wb_slot
    import wb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             clear,
    input  wb_blk_t          blk_in,
    input  logic             probe_en,
    input  logic [TAG_W-1:0] probe_tag,
    output wb_blk_t          blk_out,
    output logic             hit
);
    logic    occupied;
    wb_blk_t blk_q;

    // Occupied flag: set on capture, cleared on retire or reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            occupied <= 1'b0;
        else if (load)
            occupied <= 1'b1;
        else if (clear)
            occupied <= 1'b0;
    end

    // Record storage, written only on capture.
    always_ff @(posedge clk) begin
        if (load)
            blk_q <= blk_in;
    end

    // Load overlap comparator on block address.
    always_comb begin
        blk_out = blk_q;
        hit     = occupied && probe_en && (blk_q.tag == probe_tag);
    end

    // R2
    slot_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> occupied && (blk_q == $past(blk_in)));

    // R3
    slot_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear && !load |=> !occupied);
endmodule

// File: rtl/write_buffer.sv
// Module write_buffer
// Posted write buffer between a data cache and memory. Holds store misses
// and dirty evictions as 16-byte blocks with byte masks, drains them oldest
// first over a req/ack port and stalls loads that overlap a pending block.
// Assumes mem_ack is only raised while mem_req is high.
module write_buffer
    import wb_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_valid,
    input  logic [TAG_W-1:0]     wr_blk_addr,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [BLK_BYTES-1:0] wr_mask,
    output logic                 wb_full,
    input  logic                 ld_valid,
    input  logic [TAG_W-1:0]     ld_blk_addr,
    output logic                 ld_stall,
    output logic                 mem_req,
    output logic [TAG_W-1:0]     mem_blk_addr,
    output logic [DATA_W-1:0]    mem_data,
    output logic [BLK_BYTES-1:0] mem_mask,
    input  logic                 mem_ack
);
    logic             push_ok;
    logic             pop;
    logic             empty;
    logic             full;
    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] rd_idx;
    logic [DEPTH-1:0] slot_hit;
    wb_blk_t          slot_blk [DEPTH];
    wb_blk_t          in_blk;
    wb_blk_t          head_blk;

    // Pack the incoming write and pick the oldest slot for memory.
    always_comb begin
        in_blk.tag  = wr_blk_addr;
        in_blk.data = wr_data;
        in_blk.mask = wr_mask;
        head_blk    = slot_blk[rd_idx];
        mem_req     = !empty;
        pop         = mem_req && mem_ack;
        wb_full     = full;
        ld_stall    = |slot_hit;
    end

    assign mem_blk_addr = head_blk.tag;
    assign mem_data     = head_blk.data;
    assign mem_mask     = head_blk.mask;

    wb_ptr_ctrl #(.DEPTH(DEPTH)) ptr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_req (wr_valid),
        .pop      (pop),
        .push_ok  (push_ok),
        .wr_idx   (wr_idx),
        .rd_idx   (rd_idx),
        .empty    (empty),
        .full     (full)
    );

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        wb_slot slot_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (push_ok && (wr_idx == IDX_W'(g))),
            .clear     (pop && (rd_idx == IDX_W'(g))),
            .blk_in    (in_blk),
            .probe_en  (ld_valid),
            .probe_tag (ld_blk_addr),
            .blk_out   (slot_blk[g]),
            .hit       (slot_hit[g])
        );
    end

    // R3
    offer_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_blk_addr)
                                && $stable(mem_data) && $stable(mem_mask));

    // R5
    stall_needs_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_stall |-> mem_req && ld_valid);

    // R4
    stall_onehot_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_full |-> mem_req);
endmodule

// File: tb/write_buffer_tb_top.sv
module write_buffer_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_valid = 1'b0;
    logic [27:0]  wr_blk_addr = '0;
    logic [127:0] wr_data = '0;
    logic [15:0]  wr_mask = '0;
    logic         wb_full;
    logic         ld_valid = 1'b0;
    logic [27:0]  ld_blk_addr = '0;
    logic         ld_stall;
    logic         mem_req;
    logic [27:0]  mem_blk_addr;
    logic [127:0] mem_data;
    logic [15:0]  mem_mask;
    logic         mem_ack = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [27:0]  q_tag [$];
    logic [127:0] q_data [$];
    logic [15:0]  q_mask [$];
    logic [7:0]   exp_mem [int unsigned];
    logic [7:0]   obs_mem [int unsigned];

    always #4 clk = ~clk;

    write_buffer dut_i (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_blk_addr(wr_blk_addr), .wr_data(wr_data),
        .wr_mask(wr_mask), .wb_full(wb_full),
        .ld_valid(ld_valid), .ld_blk_addr(ld_blk_addr), .ld_stall(ld_stall),
        .mem_req(mem_req), .mem_blk_addr(mem_blk_addr), .mem_data(mem_data),
        .mem_mask(mem_mask), .mem_ack(mem_ack)
    );

    // Vector: [49] load probe, [48] expected stall, [47:16] byte address, [15:0] mask
    localparam logic [49:0] VEC [10] = '{
        {1'b0, 1'b0, 32'h1000_0040, 16'hFFFF},
        {1'b0, 1'b0, 32'h2000_0010, 16'h000F},
        {1'b1, 1'b1, 32'h1000_004C, 16'h0000},
        {1'b1, 1'b0, 32'h1000_0050, 16'h0000},
        {1'b0, 1'b0, 32'h3000_00F0, 16'hF0F0},
        {1'b1, 1'b1, 32'h2000_001C, 16'h0000},
        {1'b1, 1'b1, 32'h3000_00F8, 16'h0000},
        {1'b1, 1'b0, 32'h4000_0000, 16'h0000},
        {1'b0, 1'b0, 32'h1000_0040, 16'h00FF},
        {1'b1, 1'b0, 32'h2000_0000, 16'h0000}
    };

    task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] mk_data(int k, logic [31:0] a);
        return {a ^ 32'(k * 4 + 3), a ^ 32'(k * 4 + 2),
                a ^ 32'(k * 4 + 1), a ^ 32'(k * 4 + 16'h5A00)};
    endfunction

    task automatic push(logic [27:0] tag, logic [127:0] d, logic [15:0] m, bit expect_keep);
        @(negedge clk);
        wr_valid = 1'b1; wr_blk_addr = tag; wr_data = d; wr_mask = m;
        @(negedge clk);
        wr_valid = 1'b0;
        if (expect_keep) begin
            q_tag.push_back(tag); q_data.push_back(d); q_mask.push_back(m);
        end
    endtask

    task automatic probe(string req, logic [27:0] tag, logic exp);
        @(negedge clk);
        ld_valid = 1'b1; ld_blk_addr = tag;
        #1 chk(req, ld_stall, exp);
        ld_valid = 1'b0;
    endtask

    task automatic drain(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
            chk("R3 req", mem_req, 1'b1);
            chk("R3 order addr", mem_blk_addr, q_tag[0]);
            chk("R2 data", mem_data, q_data[0]);
            chk("R2 mask", mem_mask, q_mask[0]);
            @(negedge clk); #1;
            chk("R3 held", mem_data, q_data[0]);
            mem_ack = 1'b1;
            for (int b = 0; b < 16; b++) begin
                if (mem_mask[b]) obs_mem[{mem_blk_addr, 4'(b)}] = mem_data[8*b +: 8];
                if (q_mask[0][b]) exp_mem[{q_tag[0], 4'(b)}] = q_data[0][8*b +: 8];
            end
            void'(q_tag.pop_front()); void'(q_data.pop_front()); void'(q_mask.pop_front());
            @(negedge clk);
            mem_ack = 1'b0;
        end
        #1 chk("R3 empty after drain", mem_req, 1'b0);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        q_tag.delete(); q_data.delete(); q_mask.delete();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        chk("R1 req", mem_req, 1'b0);
        chk("R1 full", wb_full, 1'b0);
        ld_valid = 1'b1; ld_blk_addr = 28'h0;
        #1 chk("R1 stall", ld_stall, 1'b0);
        ld_valid = 1'b0;

        // Table phase: memory holds off, probes see pending slots (R5, R6).
        for (int v = 0; v < 10; v++) begin
            if (VEC[v][49])
                probe(VEC[v][48] ? "R5 overlap" : "R6 bypass", VEC[v][47:20], VEC[v][48]);
            else
                push(VEC[v][47:20], mk_data(v, VEC[v][47:16]), VEC[v][15:0], 1'b1);
        end
        // Drain and compare with the reference memory (R3, R8).
        drain(4);
        begin
            int mism = 0;
            foreach (exp_mem[k]) if (!obs_mem.exists(k) || obs_mem[k] !== exp_mem[k]) mism++;
            chk("R8 memory image", 128'(mism), 128'd0);
            chk("R8 merged byte", 128'(obs_mem[32'h1000_0048]), 128'(exp_mem[32'h1000_0048]));
        end

        // Full back-pressure and dropped write (R4).
        for (int i = 0; i < 7; i++) push(28'h600_0000 + 28'(i), mk_data(20 + i, 32'(i)), 16'hFFFF, 1'b1);
        #1 chk("R4 not full at 7", wb_full, 1'b0);
        push(28'h600_0007, mk_data(27, 32'd7), 16'h0F0F, 1'b1);
        #1 chk("R4 full at 8", wb_full, 1'b1);
        push(28'h770_0000, mk_data(28, 32'd8), 16'hFFFF, 1'b0);
        #1 chk("R4 still full", wb_full, 1'b1);
        probe("R4 dropped write not stalling", 28'h770_0000, 1'b0);
        drain(8);

        // Stall release timing (R7).
        push(28'h500_0002, mk_data(30, 32'h5000_0020), 16'h00F0, 1'b1);
        @(negedge clk);
        ld_valid = 1'b1; ld_blk_addr = 28'h500_0002;
        #1 chk("R5 stall before ack", ld_stall, 1'b1);
        mem_ack = 1'b1;
        #1 chk("R7 held in ack cycle", ld_stall, 1'b1);
        @(negedge clk);
        mem_ack = 1'b0;
        #1 chk("R7 released after ack", ld_stall, 1'b0);
        ld_valid = 1'b0;
        void'(q_tag.pop_front()); void'(q_data.pop_front()); void'(q_mask.pop_front());

        // Reset empties pending writes (R1).
        push(28'h800_0001, mk_data(40, 32'h1), 16'hFFFF, 1'b1);
        push(28'h800_0002, mk_data(41, 32'h2), 16'hFFFF, 1'b1);
        do_reset();
        #1;
        chk("R1 req after reset", mem_req, 1'b0);
        chk("R1 full after reset", wb_full, 1'b0);
        probe("R1 no stall after reset", 28'h800_0001, 1'b0);
        repeat (3) @(negedge clk);
        #1 chk("R1 nothing delivered", mem_req, 1'b0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule